// File: doc/BRIEF.md
# Vector Floating-Point maxNum Reduction

This unit takes one packed vector operand and returns its largest element as a scalar. Comparisons follow IEEE 754-2008 maxNum rules. A quiet NaN loses to any number. A signalling NaN raises an invalid-operation flag. Two quiet NaNs give the default quiet NaN. All other pairs behave like an ordinary floating-point maximum.

The unit accepts two element formats. Half precision uses 16-bit lanes, with 4 or 8 lanes selected by the length bit. Single precision uses 4 lanes of 32 bits. The caller presents the operand, the precision and length selects and a valid strobe. Exactly one clock later the unit returns:
- the zero-extended scalar,
- the invalid flag,
- an undefined-configuration flag for the one illegal shape,
- a valid strobe.

The reduction is a balanced tree. Lanes are paired with their neighbours, the lower lane always being the first operand. As a result, tie and NaN outcomes are fixed by lane position.

Top module: `vec_maxnum_reduce`

## Requirements
- R1: With selSingle=1 and selWide=1, the 128-bit operand holds four 32-bit lanes, lane i in bits [32i+31:32i]. The result is the largest lane value.
- R2: With selSingle=0 and selWide=1, the operand holds eight 16-bit lanes, lane i in bits [16i+15:16i]. The result is the largest of all eight lanes.
- R3: With selSingle=0 and selWide=0, only lanes 0 to 3 (bits [63:0]) take part. Bits [127:64] affect neither the result nor the invalid flag.
- R4: When one operand of a comparison is a quiet NaN (exponent all ones, top mantissa bit 1) and the other is a number, the comparison yields the number.
- R5: A signalling NaN (exponent all ones, top mantissa bit 0, mantissa non-zero) in any participating lane sets outInvalid. Any comparison that involves a signalling NaN yields the default quiet NaN: 0x7E00 for half, 0x7FC00000 for single. Later comparisons treat that value as a quiet NaN.
- R6: A comparison of two quiet NaNs yields the default quiet NaN and leaves outInvalid clear.
- R7: Positive zero ranks above negative zero. When two operands are equal, the lower lane's value is kept.
- R8: Subnormals are compared by their exact value, with no flushing. Negative values and infinities are ordered by numeric value.
- R9: outScalar is 32 bits wide. A half-precision result sits in bits [15:0], and bits [31:16] are zero.
- R10: The combination selSingle=1, selWide=0 is illegal. For it the unit sets outUndef, drives outScalar to zero and clears outInvalid.
- R11: outValid is inValid delayed by exactly one cycle. While inValid is low, outScalar, outInvalid and outUndef hold their values.
- R12: After reset, outValid, outScalar, outInvalid and outUndef are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand and selects are valid this cycle |
| inVec | input | 128 | Packed vector operand (VEC_W) |
| selSingle | input | 1 | 1 = single-precision lanes, 0 = half-precision lanes |
| selWide | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| outValid | output | 1 | Result valid, one cycle after inValid |
| outScalar | output | 32 | Zero-extended maximum element (RES_W) |
| outInvalid | output | 1 | A signalling NaN was seen in a participating lane |
| outUndef | output | 1 | The selected precision/length pair is illegal |

## Verification
The bench builds the unit with its default parameters: a 128-bit vector and the half and single exponent/mantissa widths. This gives an 8-lane half tree and a 4-lane single tree. With these values, the 4-lane half result comes from the lower subtree of the 8-lane tree. Garbage placed in the upper 64 bits, including signalling NaNs and infinities, can then be shown to have no effect. Lane patterns are chosen so that the default NaN produced at the first tree level meets a number at the root. This exposes the pairing order and the quiet-NaN rule together.

// File: rtl/vmx_pkg.sv
`timescale 1ns/1ps
package vmx_pkg;
  // Strobes handed from the control block to the datapath
  typedef struct packed {
    logic capture;    // register a new result this cycle
    logic useSingle;  // select the single-precision tree
    logic useWide;    // 128-bit vector in half mode
    logic undef;      // illegal shape: force zero result
  } vmx_ctrl_t;
endpackage

// File: rtl/vmx_maxnum_cell.sv
`timescale 1ns/1ps
module vmx_maxnum_cell #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10
) (
  input  logic [EXP_W+MAN_W:0] opA,  // lower-lane operand
  input  logic [EXP_W+MAN_W:0] opB,  // upper-lane operand
  output logic [EXP_W+MAN_W:0] maxOut
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic aNan, bNan, aQuiet, bQuiet, aSig, bSig, bGreater;

  always_comb begin
    aNan   = (&opA[W-2:MAN_W]) && (|opA[MAN_W-1:0]);
    bNan   = (&opB[W-2:MAN_W]) && (|opB[MAN_W-1:0]);
    aQuiet = aNan && opA[MAN_W-1];
    bQuiet = bNan && opB[MAN_W-1];
    aSig   = aNan && !opA[MAN_W-1];
    bSig   = bNan && !opB[MAN_W-1];

    // Sign-magnitude ordering; +0 ranks above -0 through the sign test
    if (opA[W-1] != opB[W-1])
      bGreater = opA[W-1];
    else if (!opA[W-1])
      bGreater = opB[W-2:0] > opA[W-2:0];
    else
      bGreater = opB[W-2:0] < opA[W-2:0];

    if (aSig || bSig)
      maxOut = DEF_NAN;
    else if (aQuiet && bQuiet)
      maxOut = DEF_NAN;
    else if (aQuiet)
      maxOut = opB;
    else if (bQuiet)
      maxOut = opA;
    else if (bGreater)
      maxOut = opB;
    else
      maxOut = opA;
  end
endmodule

// File: rtl/vmx_tree.sv
`timescale 1ns/1ps
module vmx_tree #(
  parameter int LANES = 8,
  parameter int EXP_W = 5,
  parameter int MAN_W = 10
) (
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0] lanesIn,
  output logic [EXP_W+MAN_W:0]             rootOut,    // max over all lanes
  output logic [EXP_W+MAN_W:0]             lowHalfOut  // max over lower half
);
  localparam int W      = 1 + EXP_W + MAN_W;
  localparam int LEVELS = $clog2(LANES);

  for (genvar k = 0; k <= LEVELS; k++) begin : g_lvl
    localparam int N = LANES >> k;
    logic [N*W-1:0] vals;
    if (k == 0) begin : g_leaf
      assign vals = lanesIn;
    end else begin : g_node
      for (genvar j = 0; j < N; j++) begin : g_cell
        vmx_maxnum_cell #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cell (
          .opA   (g_lvl[k-1].vals[(2*j)*W +: W]),
          .opB   (g_lvl[k-1].vals[(2*j+1)*W +: W]),
          .maxOut(vals[j*W +: W])
        );
      end
    end
  end

  assign rootOut    = g_lvl[LEVELS].vals;
  assign lowHalfOut = g_lvl[LEVELS-1].vals[W-1:0];
endmodule

// File: rtl/vmx_control.sv
`timescale 1ns/1ps
module vmx_control
  import vmx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      selSingle,
  input  logic      selWide,
  output vmx_ctrl_t ctrl,
  output logic      outValid
);
  always_comb begin
    ctrl.capture   = inValid;
    ctrl.undef     = selSingle && !selWide;
    ctrl.useSingle = selSingle && selWide;
    ctrl.useWide   = selWide;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/vmx_datapath.sv
`timescale 1ns/1ps
module vmx_datapath
  import vmx_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int HALF_EXP = 5,
  parameter int HALF_MAN = 10,
  parameter int SGL_EXP  = 8,
  parameter int SGL_MAN  = 23
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  vmx_ctrl_t                   ctrl,
  input  logic [VEC_W-1:0]            vecIn,
  output logic [SGL_EXP+SGL_MAN:0]    resOut,
  output logic                        invalidOut,
  output logic                        undefOut
);
  localparam int HALF_W     = 1 + HALF_EXP + HALF_MAN;
  localparam int SGL_W      = 1 + SGL_EXP + SGL_MAN;
  localparam int HALF_LANES = VEC_W / HALF_W;
  localparam int NARROW     = HALF_LANES / 2;
  localparam int SGL_LANES  = VEC_W / SGL_W;

  logic [HALF_W-1:0] halfRoot, halfLow;
  logic [SGL_W-1:0]  sglRoot, sglLow;
  logic [HALF_LANES-1:0] halfSig;
  logic [SGL_LANES-1:0]  sglSig;

  vmx_tree #(.LANES(HALF_LANES), .EXP_W(HALF_EXP), .MAN_W(HALF_MAN)) u_halfTree (
    .lanesIn(vecIn), .rootOut(halfRoot), .lowHalfOut(halfLow)
  );
  vmx_tree #(.LANES(SGL_LANES), .EXP_W(SGL_EXP), .MAN_W(SGL_MAN)) u_sglTree (
    .lanesIn(vecIn), .rootOut(sglRoot), .lowHalfOut(sglLow)
  );

  // Signalling-NaN detectors per lane
  for (genvar i = 0; i < HALF_LANES; i++) begin : g_halfSig
    logic [HALF_W-1:0] lane;
    assign lane = vecIn[i*HALF_W +: HALF_W];
    assign halfSig[i] = (&lane[HALF_W-2:HALF_MAN]) && !lane[HALF_MAN-1]
                        && (|lane[HALF_MAN-2:0]);
  end
  for (genvar i = 0; i < SGL_LANES; i++) begin : g_sglSig
    logic [SGL_W-1:0] lane;
    assign lane = vecIn[i*SGL_W +: SGL_W];
    assign sglSig[i] = (&lane[SGL_W-2:SGL_MAN]) && !lane[SGL_MAN-1]
                       && (|lane[SGL_MAN-2:0]);
  end

  logic [SGL_W-1:0] resNext;
  logic             invNext;

  always_comb begin
    if (ctrl.undef) begin
      resNext = '0;
      invNext = 1'b0;
    end else if (ctrl.useSingle) begin
      resNext = sglRoot;
      invNext = |sglSig;
    end else if (ctrl.useWide) begin
      resNext = {{(SGL_W-HALF_W){1'b0}}, halfRoot};
      invNext = |halfSig;
    end else begin
      resNext = {{(SGL_W-HALF_W){1'b0}}, halfLow};
      invNext = |halfSig[NARROW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resOut     <= '0;
      invalidOut <= 1'b0;
      undefOut   <= 1'b0;
    end else if (ctrl.capture) begin
      resOut     <= resNext;
      invalidOut <= invNext;
      undefOut   <= ctrl.undef;
    end
  end
endmodule

// File: rtl/vec_maxnum_reduce.sv
`timescale 1ns/1ps
module vec_maxnum_reduce
  import vmx_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int HALF_EXP = 5,
  parameter int HALF_MAN = 10,
  parameter int SGL_EXP  = 8,
  parameter int SGL_MAN  = 23,
  localparam int RES_W   = 1 + SGL_EXP + SGL_MAN
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [VEC_W-1:0] inVec,
  input  logic             selSingle,
  input  logic             selWide,
  output logic             outValid,
  output logic [RES_W-1:0] outScalar,
  output logic             outInvalid,
  output logic             outUndef
);
  vmx_ctrl_t ctrl;

  vmx_control u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .selSingle(selSingle), .selWide(selWide),
    .ctrl(ctrl), .outValid(outValid)
  );

  vmx_datapath #(
    .VEC_W(VEC_W), .HALF_EXP(HALF_EXP), .HALF_MAN(HALF_MAN),
    .SGL_EXP(SGL_EXP), .SGL_MAN(SGL_MAN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .vecIn(inVec),
    .resOut(outScalar), .invalidOut(outInvalid), .undefOut(outUndef)
  );
endmodule

// File: rtl/vec_maxnum_reduce_chk.sv
`timescale 1ns/1ps
module vec_maxnum_reduce_chk #(
  parameter int VEC_W = 128,
  parameter int RES_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [VEC_W-1:0] inVec,
  input logic             selSingle,
  input logic             selWide,
  input logic             outValid,
  input logic [RES_W-1:0] outScalar,
  input logic             outInvalid,
  input logic             outUndef
);
  // R11
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R11
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outScalar) && $stable(outInvalid) && $stable(outUndef)));
  // R10
  undef_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && selSingle && !selWide) |=> (outUndef && outScalar == '0 && !outInvalid));
  // R10
  legal_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && selWide) |=> !outUndef);
  // R9
  half_zero_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !selSingle) |=> (outScalar[RES_W-1:16] == '0));
  // R3
  narrow_upper_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !selSingle && !selWide && inVec[63:0] == '0) |=> (outScalar == '0 && !outInvalid));
endmodule

bind vec_maxnum_reduce vec_maxnum_reduce_chk #(.VEC_W(VEC_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inVec(inVec),
  .selSingle(selSingle), .selWide(selWide), .outValid(outValid),
  .outScalar(outScalar), .outInvalid(outInvalid), .outUndef(outUndef)
);

// File: tb/test_vec_maxnum_reduce.sv
`timescale 1ns/1ps
module test_vec_maxnum_reduce;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] inVec = '0;
  logic         selSingle = 1'b0;
  logic         selWide = 1'b0;
  logic         outValid;
  logic [31:0]  outScalar;
  logic         outInvalid;
  logic         outUndef;

  int testsRun = 0;
  int testsFailed = 0;
  int cycle = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        inv;
    logic        und;
    int          cyc;
    string       tag;
  } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  vec_maxnum_reduce i_vec_maxnum_reduce (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inVec(inVec),
    .selSingle(selSingle), .selWide(selWide), .outValid(outValid),
    .outScalar(outScalar), .outInvalid(outInvalid), .outUndef(outUndef)
  );

  function automatic logic [63:0] h4(input logic [15:0] l0, l1, l2, l3);
    return {l3, l2, l1, l0};
  endfunction
  function automatic logic [127:0] s4(input logic [31:0] l0, l1, l2, l3);
    return {l3, l2, l1, l0};
  endfunction

  task automatic drive(input logic [127:0] v, input logic sg, input logic wd,
                       input logic [31:0] er, input logic ei, input logic eu,
                       input string tag);
    item_t it;
    @(posedge clk); #1;
    inVec = v; selSingle = sg; selWide = wd; inValid = 1'b1;
    it.res = er; it.inv = ei; it.und = eu; it.cyc = cycle; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      inValid = 1'b0;
      inVec = {4{32'hDEAD_BEEF}};
    end
  endtask

  // Scoreboard monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (rstN && outValid) begin
      item_t it;
      testsRun++;
      if (expQ.size() == 0) begin
        testsFailed++;
        $display("FAIL R11 unexpected outValid: actual 1 expected 0");
      end else begin
        it = expQ.pop_front();
        if (outScalar !== it.res || outInvalid !== it.inv || outUndef !== it.und
            || cycle != it.cyc + 1) begin
          testsFailed++;
          $display("FAIL %s: actual res=%h inv=%b und=%b lat=%0d expected res=%h inv=%b und=%b lat=1",
                   it.tag, outScalar, outInvalid, outUndef, cycle - it.cyc,
                   it.res, it.inv, it.und);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testsRun++;
    if (outValid !== 1'b0 || outScalar !== '0 || outInvalid !== 1'b0 || outUndef !== 1'b0) begin
      testsFailed++;
      $display("FAIL R12 reset: actual v=%b res=%h inv=%b und=%b expected all zero",
               outValid, outScalar, outInvalid, outUndef);
    end
    @(posedge clk); #1 rstN = 1'b1;

    // R1 single, 4 lanes: 1.0, -3.0, 2.0, 0.5 -> 2.0
    drive(s4(32'h3F80_0000, 32'hC040_0000, 32'h4000_0000, 32'h3F00_0000), 1, 1,
          32'h4000_0000, 0, 0, "R1 single max");
    // R2 half, 8 lanes, max 4.0 in lane 7
    drive({h4(16'hC000, 16'h0001, 16'h3800, 16'h4400), h4(16'h3C00, 16'h4000, 16'hBC00, 16'h4200)},
          0, 1, 32'h0000_4400, 0, 0, "R2/R9 half wide max");
    // R3 half narrow: upper half holds +inf and sNaN, must be ignored
    drive({h4(16'h7C00, 16'h7D00, 16'h7C00, 16'h7D00), h4(16'h3C00, 16'h4000, 16'hBC00, 16'h3800)},
          0, 0, 32'h0000_4000, 0, 0, "R3/R9 half narrow upper ignored");
    // R4 qNaN vs number: (qNaN,-1)->-1, (-inf,qNaN)->-inf, root -1
    drive({64'hFFFF_FFFF_FFFF_FFFF, h4(16'h7E00, 16'hBC00, 16'hFC00, 16'h7E01)},
          0, 0, 32'h0000_BC00, 0, 0, "R4 quiet NaN loses");
    // R5 sNaN in lane 0: pair -> default NaN, then loses to 3.0
    drive({64'h0, h4(16'h7D00, 16'h3C00, 16'h4000, 16'h4200)},
          0, 0, 32'h0000_4200, 1, 0, "R5 half sNaN flag");
    // R5 single: (sNaN,qNaN) -> default NaN, (1.0,2.0) -> 2.0
    drive(s4(32'h7FA0_0000, 32'h7FC0_0000, 32'h3F80_0000, 32'h4000_0000), 1, 1,
          32'h4000_0000, 1, 0, "R5 single sNaN flag");
    // R5 all sNaN in 8 lanes -> default NaN
    drive({8{16'h7D01}}, 0, 1, 32'h0000_7E00, 1, 0, "R5 all sNaN default NaN");
    // R6 all quiet NaNs with payloads -> default NaN, no flag
    drive({h4(16'h7E07, 16'hFF00, 16'h7E02, 16'h7E00), h4(16'h7E01, 16'hFE00, 16'h7E05, 16'h7F00)},
          0, 1, 32'h0000_7E00, 0, 0, "R6 two quiet NaNs");
    // R6 single all quiet NaNs
    drive(s4(32'h7FC0_0001, 32'hFFC0_0000, 32'h7FE0_0000, 32'h7FC0_0000), 1, 1,
          32'h7FC0_0000, 0, 0, "R6 single quiet NaNs");
    // R7 +0 above -0
    drive({64'h0, h4(16'h8000, 16'h0000, 16'h8000, 16'h8000)},
          0, 0, 32'h0000_0000, 0, 0, "R7 half signed zero");
    drive(s4(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000), 1, 1,
          32'h0000_0000, 0, 0, "R7 single signed zero");
    // R7 all equal -> value kept
    drive({64'h0, {4{16'h3C00}}}, 0, 0, 32'h0000_3C00, 0, 0, "R7 ties");
    // R8 subnormals
    drive({64'h0, h4(16'h0001, 16'h0200, 16'h8200, 16'h0000)},
          0, 0, 32'h0000_0200, 0, 0, "R8 subnormals");
    // R8 negatives only
    drive({64'h0, h4(16'hC000, 16'hBC00, 16'hFC00, 16'hC200)},
          0, 0, 32'h0000_BC00, 0, 0, "R8 negatives");
    // R8 infinity wins
    drive({h4(16'h0000, 16'h7BFF, 16'h0000, 16'h0000), h4(16'h4000, 16'h0001, 16'h7C00, 16'h3C00)},
          0, 1, 32'h0000_7C00, 0, 0, "R8 infinity");
    // R10 illegal shape, even with a signalling NaN present
    drive(s4(32'h7FA0_0000, 32'h4000_0000, 32'h3F80_0000, 32'h0), 1, 0,
          32'h0000_0000, 0, 1, "R10 undefined shape");
    // R11 hold check: last result 1.0 single, then idle
    drive(s4(32'h3F80_0000, 32'hBF80_0000, 32'h0, 32'h8000_0000), 1, 1,
          32'h3F80_0000, 0, 0, "R1 single mixed sign");
    idle(4);
    @(negedge clk);
    testsRun++;
    if (outValid !== 1'b0 || outScalar !== 32'h3F80_0000 || outInvalid !== 1'b0 || outUndef !== 1'b0) begin
      testsFailed++;
      $display("FAIL R11 hold: actual v=%b res=%h inv=%b und=%b expected v=0 res=3f800000 inv=0 und=0",
               outValid, outScalar, outInvalid, outUndef);
    end
    idle(2);
    testsRun++;
    if (expQ.size() != 0) begin
      testsFailed++;
      $display("FAIL R11 missing results: actual %0d pending expected 0", expQ.size());
    end
    finish_run();
  end
endmodule